// File: doc/BRIEF.md
# Masked Base Address Translator

This block maps addresses from the system bus onto PCI memory addresses through two windows, one for each mezzanine slot. Software sets up each window with three 16-bit registers. A match value selects the region. A mask says which upper address bits take part in the match. A translation value supplies the replacement for those masked bits. Each window is switched on by its own enable bit in a shared control register. The same control register also drives the two slot power switches and four indicator LEDs.

A lookup starts when `req_valid` is high with a 32-bit address. The result appears on the `rsp_*` outputs exactly one clock later: a hit flag, the number of the matching slot and the rebuilt PCI address. A lookup can hit only when the request is qualified as a 32-bit-space access (`req_a32`). When both windows match, slot A wins.

The design has no multi-state sequencer. Each lookup completes in one cycle, so there are no named states or transitions. The only sequential elements are the configuration registers and one output stage.

Top module: `winmap_top`

## Requirements
- R1: After reset, every window register reads 0x0000. The control register reads 0x0000. `slot_pwr`, `led`, `rsp_valid`, `rsp_hit`, `rsp_slot` and `rsp_addr` are all zero.
- R2: Registers are addressed by byte offset on `reg_addr`:
  - 0x04: control.
  - 0x0A, 0x0C, 0x0E: window A match, mask and translation.
  - 0x10, 0x12, 0x14: window B match, mask and translation.
  
  A write with `reg_wr` high takes effect at the clock edge. `reg_rdata` shows the addressed register combinationally. Any other offset reads 0x0000.
- R3: Control bit 10 enables window A and bit 11 enables window B. Bits 9 and 8 drive `slot_pwr[1]` (slot B) and `slot_pwr[0]` (slot A). Bits 3..0 drive `led[3:0]`. All other control bits read back as 0.
- R4: A window hits when all three of these hold:
  - its enable bit is set;
  - `req_a32` is high;
  - (`req_addr[31:16]` AND mask) equals (match AND mask).
- R5: On a hit, `rsp_addr[31:16]` = (`req_addr[31:16]` AND NOT mask) OR (translation AND mask), using the winning window's registers.
- R6: On a hit, `rsp_addr[15:1]` equals `req_addr[15:1]` and `rsp_addr[0]` is 0.
- R7: A window whose enable bit is clear never hits, whatever its match, mask and translation values are.
- R8: If both windows hit, the result uses window A. `rsp_slot` is 0 for window A and 1 for window B.
- R9: A request with `req_a32` low never hits.
- R10: `rsp_valid` is `req_valid` delayed by one cycle. On a miss, `rsp_slot` and `rsp_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| slot_pwr | output | 2 | Power switch per slot (bit 0 = A) |
| led | output | 4 | Indicator LED drives |
| req_valid | input | 1 | Lookup request strobe |
| req_a32 | input | 1 | Request is in the 32-bit address space |
| req_addr | input | 32 | Incoming bus address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | A window matched |
| rsp_slot | output | 1 | Index of the matching window |
| rsp_addr | output | 32 | Translated PCI address |

## Verification
The embedded properties assume three things about the inputs:
- `req_valid`, `req_a32` and `req_addr` are settled before each rising edge;
- the request inputs stay low while reset is active, so the output stage does not capture a request during reset;
- software does not write the enable bits in the same cycle as a lookup whose outcome it wants to predict.

The stimulus drives every input on the falling edge and holds requests idle during reset. It rewrites the control register only on cycles with no request in flight, so each property compares the result against the configuration that was in force when the request was sampled.

// File: rtl/winmap_pkg.sv
package winmap_pkg;
    localparam int WIN_N      = 2;
    localparam int HALF_W     = 16;
    localparam int SLOT_W     = (WIN_N > 1) ? $clog2(WIN_N) : 1;
    localparam int LED_N      = 4;
    localparam int CTRL_OFS   = 'h04;
    localparam int WIN0_OFS   = 'h0A;
    localparam int WIN_STRIDE = 6;
    localparam int MASK_REL   = 2;
    localparam int XLAT_REL   = 4;
    localparam int EN_LSB     = 10;
    localparam int PWR_LSB    = 8;

    typedef logic [HALF_W-1:0] half_t;

    typedef struct packed {
        half_t base;
        half_t mask;
        half_t xlat;
    } win_cfg_t;
endpackage

// File: rtl/winmap_regs.sv
module winmap_regs
    import winmap_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  half_t             wdata,
    output half_t             rdata,
    output win_cfg_t          cfg [WIN_N],
    output logic [WIN_N-1:0]  win_en,
    output logic [WIN_N-1:0]  pwr,
    output logic [LED_N-1:0]  led
);
    win_cfg_t         cfg_q [WIN_N];
    logic [WIN_N-1:0] en_q;
    logic [WIN_N-1:0] pwr_q;
    logic [LED_N-1:0] led_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pwr_q <= '0;
            led_q <= '0;
            for (int w = 0; w < WIN_N; w++) cfg_q[w] <= '0;
        end else if (wr_en) begin
            if (addr == AW'(CTRL_OFS)) begin
                en_q  <= wdata[EN_LSB +: WIN_N];
                pwr_q <= wdata[PWR_LSB +: WIN_N];
                led_q <= wdata[LED_N-1:0];
            end
            for (int w = 0; w < WIN_N; w++) begin
                if (addr == AW'(WIN0_OFS + w*WIN_STRIDE))            cfg_q[w].base <= wdata;
                if (addr == AW'(WIN0_OFS + w*WIN_STRIDE + MASK_REL)) cfg_q[w].mask <= wdata;
                if (addr == AW'(WIN0_OFS + w*WIN_STRIDE + XLAT_REL)) cfg_q[w].xlat <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(CTRL_OFS)) begin
            rdata[EN_LSB +: WIN_N]  = en_q;
            rdata[PWR_LSB +: WIN_N] = pwr_q;
            rdata[LED_N-1:0]        = led_q;
        end
        for (int w = 0; w < WIN_N; w++) begin
            if (addr == AW'(WIN0_OFS + w*WIN_STRIDE))            rdata = cfg_q[w].base;
            if (addr == AW'(WIN0_OFS + w*WIN_STRIDE + MASK_REL)) rdata = cfg_q[w].mask;
            if (addr == AW'(WIN0_OFS + w*WIN_STRIDE + XLAT_REL)) rdata = cfg_q[w].xlat;
        end
    end

    assign cfg    = cfg_q;
    assign win_en = en_q;
    assign pwr    = pwr_q;
    assign led    = led_q;

    // R3
    pwr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(CTRL_OFS)) |=> (pwr == $past(wdata[PWR_LSB +: WIN_N])));

    // R3
    led_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(CTRL_OFS)) |=> (led == $past(wdata[LED_N-1:0])));
endmodule

// File: rtl/winmap_match.sv
module winmap_match
    import winmap_pkg::*;
(
    input  half_t    in_hi,
    input  win_cfg_t cfg,
    input  logic     en,
    output logic     hit,
    output half_t    out_hi
);
    always_comb begin
        hit    = en && ((in_hi & cfg.mask) == (cfg.base & cfg.mask));
        out_hi = (in_hi & ~cfg.mask) | (cfg.xlat & cfg.mask);
    end
endmodule

// File: rtl/winmap_top.sv
module winmap_top
    import winmap_pkg::*;
#(
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic [1:0]        slot_pwr,
    output logic [3:0]        led,
    input  logic              req_valid,
    input  logic              req_a32,
    input  logic [31:0]       req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [0:0]        rsp_slot,
    output logic [31:0]       rsp_addr
);
    win_cfg_t          cfg [WIN_N];
    logic [WIN_N-1:0]  win_en;
    logic [WIN_N-1:0]  hits;
    half_t             hi_tr [WIN_N];

    logic              sel_hit;
    logic [SLOT_W-1:0] sel_slot;
    half_t             sel_hi;

    winmap_regs #(.AW(REG_AW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .cfg    (cfg),
        .win_en (win_en),
        .pwr    (slot_pwr),
        .led    (led)
    );

    for (genvar w = 0; w < WIN_N; w++) begin : g_win
        winmap_match u_match (
            .in_hi  (req_addr[31:16]),
            .cfg    (cfg[w]),
            .en     (win_en[w]),
            .hit    (hits[w]),
            .out_hi (hi_tr[w])
        );
    end

    // lowest index scanned last so it takes priority
    always_comb begin
        sel_hit  = 1'b0;
        sel_slot = '0;
        sel_hi   = '0;
        for (int w = WIN_N-1; w >= 0; w--) begin
            if (hits[w]) begin
                sel_hit  = 1'b1;
                sel_slot = SLOT_W'(w);
                sel_hi   = hi_tr[w];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_slot  <= '0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid && req_a32 && sel_hit) begin
                rsp_hit  <= 1'b1;
                rsp_slot <= sel_slot;
                rsp_addr <= {sel_hi, req_addr[15:1], 1'b0};
            end else begin
                rsp_hit  <= 1'b0;
                rsp_slot <= '0;
                rsp_addr <= '0;
            end
        end
    end

    // R10
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10
    idle_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_hit);

    // R9
    no_a32_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_a32) |=> !rsp_hit);

    // R6
    low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_hit || (rsp_addr[15:1] == $past(req_addr[15:1]) && !rsp_addr[0])));

    // R7
    slot_a_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && rsp_slot == 1'b0) |-> $past(win_en[0]));

    // R7
    slot_b_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && rsp_slot == 1'b1) |-> $past(win_en[1]));
endmodule

// File: tb/sim_winmap_top.sv
module sim_winmap_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [1:0]  slot_pwr;
    logic [3:0]  led;
    logic        req_valid = 1'b0;
    logic        req_a32 = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [0:0]  rsp_slot;
    logic [31:0] rsp_addr;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    winmap_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slot_pwr(slot_pwr),
        .led(led), .req_valid(req_valid), .req_a32(req_a32),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_slot(rsp_slot), .rsp_addr(rsp_addr)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        a32;
        logic        hit;
        logic        slot;
        logic [31:0] exp;
    } vec_t;

    // window A: match 0x2000 mask 0xFFF0 xlat 0x9AB0
    // window B: match 0x4000 mask 0xFF00 xlat 0x7700
    localparam vec_t VECS [7] = '{
        '{32'h2003_1235, 1'b1, 1'b1, 1'b0, 32'h9AB3_1234},
        '{32'h200F_FFFF, 1'b1, 1'b1, 1'b0, 32'h9ABF_FFFE},
        '{32'h2010_0000, 1'b1, 1'b0, 1'b0, 32'h0000_0000},
        '{32'h40AB_CDEF, 1'b1, 1'b1, 1'b1, 32'h77AB_CDEE},
        '{32'h4100_0000, 1'b1, 1'b0, 1'b0, 32'h0000_0000},
        '{32'h2003_1235, 1'b0, 1'b0, 1'b0, 32'h0000_0000},
        '{32'h40FF_0001, 1'b1, 1'b1, 1'b1, 32'h77FF_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, {16'h0, reg_rdata}, {16'h0, exp});
    endtask

    task automatic look(input string req, input logic [31:0] a, input logic q32,
                        input logic eh, input logic es, input logic [31:0] ea);
        @(negedge clk);
        req_valid = 1'b1; req_a32 = q32; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " valid"}, {31'h0, rsp_valid}, 32'h1);
        chk({req, " hit"},   {31'h0, rsp_hit},   {31'h0, eh});
        chk({req, " slot"},  {31'h0, rsp_slot},  {31'h0, es});
        chk({req, " addr"},  rsp_addr, ea);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk("R1 pwr", {30'h0, slot_pwr}, 32'h0);
        chk("R1 led", {28'h0, led}, 32'h0);
        chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        chk("R1 rsp_addr", rsp_addr, 32'h0);
        rd_chk("R1 ctrl", 8'h04, 16'h0000);
        rd_chk("R1 maskB", 8'h12, 16'h0000);
        // R7: all-zero registers, disabled, must not hit
        look("R7 reset disabled", 32'h1234_5678, 1'b1, 1'b0, 1'b0, 32'h0);

        // R2 program windows
        wr(8'h0A, 16'h2000); wr(8'h0C, 16'hFFF0); wr(8'h0E, 16'h9AB0);
        wr(8'h10, 16'h4000); wr(8'h12, 16'hFF00); wr(8'h14, 16'h7700);
        rd_chk("R2 baseA", 8'h0A, 16'h2000);
        rd_chk("R2 xlatA", 8'h0E, 16'h9AB0);
        rd_chk("R2 maskB", 8'h12, 16'hFF00);
        rd_chk("R2 unmapped", 8'h06, 16'h0000);

        // R3 control bits
        wr(8'h04, 16'hFFFF);
        rd_chk("R3 ctrl readback", 8'h04, 16'h0F0F);
        chk("R3 pwr", {30'h0, slot_pwr}, 32'h3);
        chk("R3 led", {28'h0, led}, 32'hF);
        wr(8'h04, 16'h0D05);
        chk("R3 pwr A only", {30'h0, slot_pwr}, 32'h1);
        chk("R3 led 5", {28'h0, led}, 32'h5);

        // vector table: R4 R5 R6 R9
        wr(8'h04, 16'h0C00);
        for (int i = 0; i < 7; i++) begin
            look($sformatf("R4/R5/R6/R9 vec%0d", i), VECS[i].addr, VECS[i].a32,
                 VECS[i].hit, VECS[i].slot, VECS[i].exp);
        end

        // R10 idle cycle gives no valid
        @(negedge clk);
        chk("R10 idle", {31'h0, rsp_valid}, 32'h0);

        // R8 overlap: window B moved onto A's region
        wr(8'h10, 16'h2000);
        look("R8 overlap A wins", 32'h2005_0010, 1'b1, 1'b1, 1'b0, 32'h9AB5_0010);
        wr(8'h04, 16'h0800);
        look("R7 A disabled B serves", 32'h2005_0010, 1'b1, 1'b1, 1'b1, 32'h7705_0010);
        wr(8'h04, 16'h0000);
        look("R7 both disabled", 32'h2005_0010, 1'b1, 1'b0, 1'b0, 32'h0);

        // R5 mask zero: whole space, upper bits unchanged
        wr(8'h0C, 16'h0000);
        wr(8'h04, 16'h0400);
        look("R5 mask zero", 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 32'hDEAD_BEEE);
        look("R9 mask zero no a32", 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule